// File: doc/BRIEF.md
# Programmable Parallel I/O Port with Port A Handshake

This block gives a processor three byte-wide parallel ports (A, B and C) behind a four-entry register window. The host selects the block, drives a 2-bit register address, and pulses a read or write strobe; all strobes are sampled on the rising clock edge. A control-address write either loads a new configuration word or sets/clears a single port C bit. Each pin group has a separate input vector, output vector and output enable, so the pad ring builds the tri-state buffers.

Port A runs either as a plain port or as a strobed port. In the strobed output role, a host write raises a "buffer full" flag toward the device, and the device's acknowledge pulse clears it and can raise an interrupt. In the strobed input role, a device strobe captures the byte and raises a "buffer full" flag, and the host read clears it. The handshake, flag and interrupt lines are carried on fixed port C bits. The two interrupt enables are written only through the port C single-bit command. External handshake inputs pass through a synchronizer whose depth is a parameter.

Top module: `pio_port`

## Requirements
- R1: After reset, no pin group drives (`pa_oe`, `pb_oe` and every `pc_oe` bit are 0), every output latch is 0, and port A reads return the live `pa_in` pins.
- R2: A control write with bit 7 = 1 is a configuration word. Bits 6:5 select the port A role: 01 is strobed and any other value is plain. Bit 4 = 1 makes port A input, bit 3 = 1 makes PC7..PC4 input, bit 1 = 1 makes port B input, and bit 0 = 1 makes PC3..PC0 input. Bit 2 is ignored. Every configuration write clears all output latches, both interrupt enables and all handshake flags. Example: 0x99 gives A input, B output, and all of port C input.
- R3: Addresses are 0 = port A, 1 = port B, 2 = port C, 3 = control. A control read returns 0. In plain roles, a write loads the port's output latch, which drives the pins when the group is an output. A read returns the latch for output bits and the input pins for input bits.
- R4: A control write with bit 7 = 0 is a single-bit command. Bits 3:1 pick the port C bit and bit 0 is its new value. No other latch bit changes. So 0x05 sets PC2, and 0x0D then 0x0C set and then clear PC6.
- R5: In strobed output (word 0xA1), port A always drives its latch. A port A write pulls PC7 (active-low buffer full) low on the following cycle.
- R6: In strobed output, PC6 is the active-low acknowledge input. Its falling edge returns PC7 high. Its rising edge drives PC3 (interrupt) high only if the output interrupt enable is set. That enable is set by the single-bit command on PC6. The next port A write clears PC3.
- R7: In strobed input (word 0xB1), PC4 is the active-low strobe input. Its falling edge latches `pa_in` and drives PC5 (buffer full) high. Its rising edge, with PC5 high, drives PC3 high only if the input interrupt enable is set. That enable is set by the single-bit command on PC4.
- R8: In strobed input, a port A read returns the latched byte and not the live pins. PC3 is cleared on the first cycle of the read. PC5 is cleared on the cycle after the read strobe ends.
- R9: In strobed roles, a port C read returns the status bits. For output, bit 7 = buffer-full line, bit 6 = output enable flop, bit 3 = interrupt. For input, bit 5 = buffer full, bit 4 = input enable flop, bit 3 = interrupt.
- R10: Handshake inputs pass through SYNC_STAGES flops before edge detection, so a pin change takes effect within SYNC_STAGES+2 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Block select |
| bus_rd | input | 1 | Read strobe, may be held several cycles |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pins in |
| pa_out | output | 8 | Port A pins out |
| pa_oe | output | 1 | Port A drive enable |
| pb_in | input | 8 | Port B pins in |
| pb_out | output | 8 | Port B pins out |
| pb_oe | output | 1 | Port B drive enable |
| pc_in | input | 8 | Port C pins in |
| pc_out | output | 8 | Port C pins out |
| pc_oe | output | 8 | Port C per-bit drive enable |

## Verification
The embedded properties check, on every cycle, several handshake rules. A port A write in strobed output pulls the buffer-full line low. Acknowledge falling releases it. An interrupt appears only after an acknowledge rise with the enable set. A strobe falling edge sets input buffer full. A read start clears the interrupt. A configuration write clears every flag. A single-bit command touches only its bit. Some behaviour needs the bench's directed scenarios to show: which byte a strobed read returns while the pins have already moved on, the status layout of port C reads, the interrupt staying low when an enable is clear, and the synchronizer delay. Randomised plain-mode directions and data, and random single-bit command sequences, are compared against bench models.

// File: rtl/pio_pkg.sv
package pio_pkg;

   typedef enum logic [1:0] {
      REG_PA  = 2'd0,
      REG_PB  = 2'd1,
      REG_PC  = 2'd2,
      REG_CTL = 2'd3
   } pio_reg_e;

   typedef struct packed {
      logic a_strobed;
      logic a_in;
      logic cu_in;
      logic b_in;
      logic cl_in;
   } pio_cfg_t;

   // Port C positions used by the port A handshake
   localparam int PC_INTR = 3;
   localparam int PC_STB  = 4;
   localparam int PC_IBF  = 5;
   localparam int PC_ACK  = 6;
   localparam int PC_OBF  = 7;

   function automatic pio_cfg_t decode_cfg(input logic [7:0] w);
      pio_cfg_t c;
      c.a_strobed = (w[6:5] == 2'b01);
      c.a_in      = w[4];
      c.cu_in     = w[3];
      c.b_in      = w[1];
      c.cl_in     = w[0];
      return c;
   endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic [W-1:0] rise,
   output logic [W-1:0] fall
);
   logic [STAGES-1:0][W-1:0] stg;
   logic [W-1:0]             prev;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '1;
            else        stg <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg <= '1;
            else        stg <= {stg[STAGES-2:0], d};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= stg[STAGES-1];
   end

   assign q    = stg[STAGES-1];
   assign rise = q & ~prev;
   assign fall = ~q & prev;
endmodule

// File: rtl/pio_handshake.sv
module pio_handshake (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       m1_out,
   input  logic       m1_in,
   input  logic       clr,
   input  logic       wr_a,
   input  logic       rd_start,
   input  logic       rd_end,
   input  logic       ack_fall,
   input  logic       ack_rise,
   input  logic       stb_fall,
   input  logic       stb_rise,
   input  logic       bsr_we,
   input  logic [2:0] bsr_sel,
   input  logic       bsr_val,
   output logic       obf_n,
   output logic       ibf,
   output logic       intr,
   output logic       inte_out,
   output logic       inte_in
);
   import pio_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         obf_n    <= 1'b1;
         ibf      <= 1'b0;
         intr     <= 1'b0;
         inte_out <= 1'b0;
         inte_in  <= 1'b0;
      end else if (clr) begin
         obf_n    <= 1'b1;
         ibf      <= 1'b0;
         intr     <= 1'b0;
         inte_out <= 1'b0;
         inte_in  <= 1'b0;
      end else begin
         if (bsr_we && m1_out && bsr_sel == 3'(PC_ACK)) inte_out <= bsr_val;
         if (bsr_we && m1_in  && bsr_sel == 3'(PC_STB)) inte_in  <= bsr_val;
         if (m1_out) begin
            if (wr_a) begin
               obf_n <= 1'b0;
               intr  <= 1'b0;
            end else begin
               if (ack_fall)             obf_n <= 1'b1;
               if (ack_rise && inte_out) intr  <= 1'b1;
            end
         end
         if (m1_in) begin
            if (stb_fall)    ibf <= 1'b1;
            else if (rd_end) ibf <= 1'b0;
            if (stb_rise && inte_in && ibf) intr <= 1'b1;
            else if (rd_start)              intr <= 1'b0;
         end
      end
   end

   p_obf_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m1_out && wr_a && !clr) |=> !obf_n);
   p_obf_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (m1_out && ack_fall && !wr_a) |=> obf_n);
   p_intr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(intr) && $past(m1_out)) |-> ($past(ack_rise) && $past(inte_out)));
   p_ibf_on_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (m1_in && stb_fall && !clr) |=> ibf);
   p_intr_rd_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (m1_in && rd_start && !stb_rise) |=> !intr);
   p_clear_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (obf_n && !ibf && !intr && !inte_out && !inte_in));
endmodule

// File: rtl/pio_port.sv
module pio_port #(
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] RESET_WORD  = 8'h9B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_rd,
   input  logic       bus_wr,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic [7:0] pa_in,
   output logic [7:0] pa_out,
   output logic       pa_oe,
   input  logic [7:0] pb_in,
   output logic [7:0] pb_out,
   output logic       pb_oe,
   input  logic [7:0] pc_in,
   output logic [7:0] pc_out,
   output logic [7:0] pc_oe
);
   import pio_pkg::*;

   localparam int HS_W = 2;

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (RESET_WORD[7] != 1'b1) begin : g_bad_reset
         $error("RESET_WORD must be a configuration word");
      end
   endgenerate

   pio_cfg_t   cfg;
   logic [7:0] pa_lat, pb_lat, pc_lat, pa_hold;
   logic       wr_ctl, cfg_we, bsr_we;
   logic       m1_out, m1_in, rd_a, rd_a_q;
   logic       obf_n, ibf, intr, inte_out, inte_in;
   logic [HS_W-1:0] hs_q, hs_rise, hs_fall;

   assign wr_ctl = bus_sel && bus_wr && bus_addr == REG_CTL;
   assign cfg_we = wr_ctl && bus_wdata[7];
   assign bsr_we = wr_ctl && !bus_wdata[7];
   assign m1_out = cfg.a_strobed && !cfg.a_in;
   assign m1_in  = cfg.a_strobed && cfg.a_in;
   assign rd_a   = bus_sel && bus_rd && bus_addr == REG_PA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg    <= decode_cfg(RESET_WORD);
         pa_lat <= '0;
         pb_lat <= '0;
         pc_lat <= '0;
         rd_a_q <= 1'b0;
      end else begin
         rd_a_q <= rd_a;
         if (cfg_we) begin
            cfg    <= decode_cfg(bus_wdata);
            pa_lat <= '0;
            pb_lat <= '0;
            pc_lat <= '0;
         end else if (bus_sel && bus_wr) begin
            if (bus_addr == REG_PA) pa_lat <= bus_wdata;
            if (bus_addr == REG_PB) pb_lat <= bus_wdata;
            if (bus_addr == REG_PC) pc_lat <= bus_wdata;
            if (bsr_we)             pc_lat[bus_wdata[3:1]] <= bus_wdata[0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      pa_hold <= '0;
      else if (cfg_we)                 pa_hold <= '0;
      else if (m1_in && hs_fall[0])    pa_hold <= pa_in;
   end

   // bit 1 = acknowledge (PC6), bit 0 = strobe (PC4)
   pio_sync #(.W(HS_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({pc_in[PC_ACK], pc_in[PC_STB]}),
      .q    (hs_q),
      .rise (hs_rise),
      .fall (hs_fall)
   );

   pio_handshake u_hs (
      .clk     (clk),
      .rst_n   (rst_n),
      .m1_out  (m1_out),
      .m1_in   (m1_in),
      .clr     (cfg_we),
      .wr_a    (bus_sel && bus_wr && bus_addr == REG_PA),
      .rd_start(rd_a && !rd_a_q),
      .rd_end  (!rd_a && rd_a_q),
      .ack_fall(hs_fall[1]),
      .ack_rise(hs_rise[1]),
      .stb_fall(hs_fall[0]),
      .stb_rise(hs_rise[0]),
      .bsr_we  (bsr_we),
      .bsr_sel (bus_wdata[3:1]),
      .bsr_val (bus_wdata[0]),
      .obf_n   (obf_n),
      .ibf     (ibf),
      .intr    (intr),
      .inte_out(inte_out),
      .inte_in (inte_in)
   );

   assign pa_out = pa_lat;
   assign pa_oe  = !cfg.a_in;
   assign pb_out = pb_lat;
   assign pb_oe  = !cfg.b_in;

   always_comb begin
      pc_out = pc_lat;
      pc_oe  = {{4{!cfg.cu_in}}, {4{!cfg.cl_in}}};
      if (m1_out) begin
         pc_oe[PC_OBF]   = 1'b1;
         pc_out[PC_OBF]  = obf_n;
         pc_oe[PC_ACK]   = 1'b0;
         pc_oe[PC_INTR]  = 1'b1;
         pc_out[PC_INTR] = intr;
      end
      if (m1_in) begin
         pc_oe[PC_STB]   = 1'b0;
         pc_oe[PC_IBF]   = 1'b1;
         pc_out[PC_IBF]  = ibf;
         pc_oe[PC_INTR]  = 1'b1;
         pc_out[PC_INTR] = intr;
      end
   end

   logic [7:0] pc_rd;
   always_comb begin
      pc_rd = (pc_oe & pc_out) | (~pc_oe & pc_in);
      if (m1_out) pc_rd[PC_ACK] = inte_out;
      if (m1_in)  pc_rd[PC_STB] = inte_in;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && bus_rd) begin
         case (bus_addr)
            REG_PA:  bus_rdata = m1_in ? pa_hold : (cfg.a_in ? pa_in : pa_lat);
            REG_PB:  bus_rdata = cfg.b_in ? pb_in : pb_lat;
            REG_PC:  bus_rdata = pc_rd;
            default: bus_rdata = '0;
         endcase
      end
   end

   p_bsr_one_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bsr_we |=> (((pc_lat ^ $past(pc_lat)) & ~(8'd1 << $past(bus_wdata[3:1]))) == 8'd0));
   p_strobed_out_drives_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m1_out |-> (pa_oe && pc_oe[PC_OBF] && !pc_oe[PC_ACK]));
endmodule

// File: tb/pio_port_bench.sv
module pio_port_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 0, bus_rd = 0, bus_wr = 0;
   logic [1:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0, bus_rdata;
   logic [7:0] pa_in = 0, pa_out, pb_in = 0, pb_out, pc_in = 8'hFF, pc_out, pc_oe;
   logic       pa_oe, pb_oe;
   int         n_tests = 0, n_fail = 0;
   logic       done = 1'b0;

   always #4 clk = ~clk;

   pio_port u_pio_port (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
      .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = a;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_sel = 0; bus_rd = 0;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   function automatic logic [7:0] c_oe_model(input logic [7:0] w);
      return {{4{~w[3]}}, {4{~w[0]}}};
   endfunction

   function automatic logic [7:0] port_read_model(input logic is_in, input logic [7:0] pins,
                                                  input logic [7:0] lat);
      return is_in ? pins : lat;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, w, da, db, dc, oe, pcm;
      int seed;
      seed = 7;
      v = $urandom(seed);
      pa_in = 8'h5E;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 pa_oe", {7'd0, pa_oe}, 8'h00);
      chk("R1 pb_oe", {7'd0, pb_oe}, 8'h00);
      chk("R1 pc_oe", pc_oe, 8'h00);
      chk("R1 pa_out", pa_out, 8'h00);
      rd(2'd0, v); chk("R1 read A pins", v, 8'h5E);

      // R2 directed 0x99
      wr(2'd3, 8'h99);
      chk("R2 0x99 pa_oe", {7'd0, pa_oe}, 8'h00);
      chk("R2 0x99 pb_oe", {7'd0, pb_oe}, 8'h01);
      chk("R2 0x99 pc_oe", pc_oe, 8'h00);

      // R2/R3 random plain-mode traffic
      for (int i = 0; i < 20; i++) begin
         w = $urandom;
         w = {1'b1, 2'b00, w[4], w[3], w[2], w[1], w[0]};
         pc_in = $urandom; pa_in = $urandom; pb_in = $urandom;
         wr(2'd3, w);
         chk("R2 latches cleared A", pa_out, 8'h00);
         chk("R2 latches cleared C", pc_out, 8'h00);
         da = $urandom; db = $urandom; dc = $urandom;
         wr(2'd0, da); wr(2'd1, db); wr(2'd2, dc);
         oe = c_oe_model(w);
         chk("R3 pa_oe", {7'd0, pa_oe}, {7'd0, ~w[4]});
         chk("R3 pb_oe", {7'd0, pb_oe}, {7'd0, ~w[1]});
         chk("R3 pc_oe", pc_oe, oe);
         chk("R3 pa_out", pa_out, da);
         rd(2'd0, v); chk("R3 read A", v, port_read_model(w[4], pa_in, da));
         rd(2'd1, v); chk("R3 read B", v, port_read_model(w[1], pb_in, db));
         rd(2'd2, v); chk("R3 read C", v, (oe & dc) | (~oe & pc_in));
         rd(2'd3, v); chk("R3 read ctl", v, 8'h00);
      end

      // R4 single-bit commands, random then directed
      pc_in = 8'hFF;
      wr(2'd3, 8'h80);
      pcm = 8'h00;
      for (int i = 0; i < 16; i++) begin
         w = $urandom;
         w = {4'b0000, w[3:1], w[0]};
         wr(2'd3, w);
         pcm[w[3:1]] = w[0];
         chk("R4 random bit command", pc_out, pcm);
      end
      wr(2'd3, 8'h80);
      wr(2'd3, 8'h05); chk("R4 0x05 sets PC2", pc_out, 8'h04);
      wr(2'd3, 8'h0D); chk("R4 0x0D sets PC6", pc_out, 8'h44);
      wr(2'd3, 8'h0C); chk("R4 0x0C clears PC6", pc_out, 8'h04);
      wr(2'd3, 8'h0D); chk("R4 PC6 toggles again", pc_out, 8'h44);

      // R5/R6/R9 strobed output
      pc_in = 8'hFF;
      wr(2'd3, 8'hA1);
      chk("R5 obf idle high", {7'd0, pc_out[7]}, 8'h01);
      chk("R5 intr idle low", {7'd0, pc_out[3]}, 8'h00);
      wr(2'd3, 8'h0D);
      rd(2'd2, v); chk("R9 inte_out in bit6", {7'd0, v[6]}, 8'h01);
      wr(2'd0, 8'h3C);
      chk("R5 pa_out data", pa_out, 8'h3C);
      chk("R5 pa driven", {7'd0, pa_oe}, 8'h01);
      chk("R5 obf low after write", {7'd0, pc_out[7]}, 8'h00);
      @(negedge clk); pc_in[6] = 1'b0; settle();
      chk("R6 ack fall releases obf", {7'd0, pc_out[7]}, 8'h01);
      chk("R6 no intr before ack rise", {7'd0, pc_out[3]}, 8'h00);
      pc_in[6] = 1'b1; settle();
      chk("R6 intr after ack rise", {7'd0, pc_out[3]}, 8'h01);
      rd(2'd2, v); chk("R9 output status bits", v & 8'hC8, 8'hC8);
      wr(2'd0, 8'h5A);
      chk("R6 write clears intr", {7'd0, pc_out[3]}, 8'h00);
      chk("R5 obf low again", {7'd0, pc_out[7]}, 8'h00);
      wr(2'd3, 8'h0C);
      pc_in[6] = 1'b0; settle(); pc_in[6] = 1'b1; settle();
      chk("R6 no intr with enable clear", {7'd0, pc_out[3]}, 8'h00);
      chk("R6 obf released", {7'd0, pc_out[7]}, 8'h01);

      // R7/R8/R9/R10 strobed input
      wr(2'd3, 8'hB1);
      chk("R2 cfg clears intr", {7'd0, pc_out[3]}, 8'h00);
      wr(2'd3, 8'h09);
      rd(2'd2, v); chk("R9 inte_in in bit4", {7'd0, v[4]}, 8'h01);
      pa_in = 8'hC3;
      @(negedge clk); pc_in[4] = 1'b0;
      @(negedge clk);
      chk("R10 ibf not yet after one edge", {7'd0, pc_out[5]}, 8'h00);
      settle();
      chk("R7 ibf after strobe", {7'd0, pc_out[5]}, 8'h01);
      chk("R7 no intr while strobe low", {7'd0, pc_out[3]}, 8'h00);
      pc_in[4] = 1'b1; settle();
      chk("R7 intr after strobe rise", {7'd0, pc_out[3]}, 8'h01);
      rd(2'd2, v); chk("R9 input status bits", v & 8'h38, 8'h38);
      pa_in = 8'h11;
      @(negedge clk);
      bus_sel = 1; bus_rd = 1; bus_addr = 2'd0;
      #1 v = bus_rdata;
      chk("R8 read returns latched byte", v, 8'hC3);
      @(negedge clk);
      chk("R8 intr cleared at read start", {7'd0, pc_out[3]}, 8'h00);
      chk("R8 ibf held during read", {7'd0, pc_out[5]}, 8'h01);
      bus_sel = 0; bus_rd = 0;
      @(negedge clk);
      chk("R8 ibf cleared after read", {7'd0, pc_out[5]}, 8'h00);
      wr(2'd3, 8'h08);
      pc_in[4] = 1'b0; settle(); pc_in[4] = 1'b1; settle();
      chk("R7 ibf with enable clear", {7'd0, pc_out[5]}, 8'h01);
      chk("R7 no intr with enable clear", {7'd0, pc_out[3]}, 8'h00);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule